// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block keeps the exception state of a stack-style floating-point unit. After each operation the datapath sends one strobe with condition bits: inexact, overflow, underflow, three further exception bits, a round-up bit, and a bit that says whether the result goes to memory or to a register. The block sets sticky flags in a status word. It writes the round-up direction into the C1 condition bit. It compares the flags with mask bits taken from the control word.

An exception whose mask bit is clear has three effects. It makes the block tell the datapath to halt the current operation. It raises the error-summary bit in the status word. The trap itself is deferred: the block requests it only when the next floating-point or wait instruction reaches issue, and that instruction is held back in its place. Precision reporting depends on two things: whether overflow or underflow came with the inexact result, and whether the destination is memory. An explicit clear input drops every flag, and this also ends any pending trap.

Top module: `fpx_flag_unit`

## Requirements
- R1: After reset the status word is all zero, and neither trap_req nor op_halt is asserted.
- R2: An inexact operation with no overflow and no underflow does two things, whatever the masks are. It sets the precision flag at status bit 5. It writes op_roundup into C1 at status bit 9.
- R3: An overflow pulse sets status bit 3, and an underflow pulse sets status bit 4. The lower exception bits set status bits 2:0. Every flag stays set until a clear.
- R4: An inexact result together with overflow or underflow sets both the matching overflow/underflow flag and the precision flag in two cases: the overflow/underflow mask is set, or the destination is a register. C1 then takes op_roundup.
- R5: Consider an operation that raises overflow or underflow with the matching mask bit clear (mask bit 3 for overflow, bit 4 for underflow) and whose destination is memory. For that operation the inexact condition is not recorded in bit 5, and C1 is cleared.
- R6: The error-summary bit at status bit 7 is the OR, over bits 5:0, of each flag whose control mask bit is zero. It follows changes of the flags and of the mask.
- R7: op_halt is asserted in the same cycle as an operation strobe that records at least one exception whose mask bit is zero. An operation that records only masked exceptions never asserts it.
- R8: An issue strobe of a floating-point or wait instruction gives one of two results in the same cycle. If the error-summary bit is set, it gives a one-cycle trap_req. Otherwise it gives issue_go.
- R9: clr_exc clears flags 5:0 at the next edge, and so the error-summary bit and any pending trap as well. An operation in the same cycle is still recorded.
- R10: An operation that records no inexact condition clears C1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation-complete strobe that carries the condition bits |
| op_inexact | input | 1 | The result was not exactly representable |
| op_ovf | input | 1 | Numeric overflow |
| op_unf | input | 1 | Numeric underflow |
| op_lo | input | 3 | Other exception conditions, mapped to flags 2:0 |
| op_roundup | input | 1 | The inexact result was rounded up |
| op_dest_mem | input | 1 | The destination is memory (1) or a register (0) |
| ctl_mask | input | 6 | Exception mask bits from the control word, 1 = masked |
| clr_exc | input | 1 | Clear all exception flags |
| issue_fp | input | 1 | A floating-point or wait instruction is at issue |
| stat_word | output | 16 | Status word: flags 5:0, summary bit 7, C1 bit 9 |
| op_halt | output | 1 | Halt the current operation because of an unmasked exception |
| trap_req | output | 1 | Trap request in place of the issuing instruction |
| issue_go | output | 1 | The issuing instruction may execute |

## Verification
A flag that is lost or wrongly set shows at the status word one edge after the operation strobe. It also changes the summary bit right away, so the next issue strobe traps when it should not, or fails to trap when it should. Errors in C1 and in the memory-destination rule show in bits 9 and 5 after that same edge. An error in halt or trap logic shows in the same cycle as the strobe. Random mask changes between operations expose a summary bit that was latched instead of computed from the live mask.

// File: rtl/fpx_flag_unit.sv
module fpx_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic        op_inexact,
  input  logic        op_ovf,
  input  logic        op_unf,
  input  logic [2:0]  op_lo,
  input  logic        op_roundup,
  input  logic        op_dest_mem,
  input  logic [5:0]  ctl_mask,
  input  logic        clr_exc,
  input  logic        issue_fp,
  output logic [15:0] stat_word,
  output logic        op_halt,
  output logic        trap_req,
  output logic        issue_go
);

  logic [5:0] flg;
  logic       c1;
  logic       esum;

  wire ou_open = (op_ovf & ~ctl_mask[3]) | (op_unf & ~ctl_mask[4]);
  wire pe_rep  = op_inexact & ~(ou_open & op_dest_mem);
  wire [5:0] raise = op_valid ? {pe_rep, op_unf, op_ovf, op_lo} : 6'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg <= '0;
      c1  <= 1'b0;
    end else begin
      flg <= (clr_exc ? 6'd0 : flg) | raise;
      if (op_valid) c1 <= pe_rep & op_roundup;
    end
  end

  assign esum      = |(flg & ~ctl_mask);
  assign stat_word = {6'd0, c1, 1'b0, esum, 1'b0, flg};
  assign op_halt   = |(raise & ~ctl_mask);
  assign trap_req  = issue_fp & esum;
  assign issue_go  = issue_fp & ~esum;

endmodule

module fpx_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_inexact,
  input logic       op_ovf,
  input logic       op_unf,
  input logic       op_dest_mem,
  input logic [5:0] ctl_mask,
  input logic       clr_exc,
  input logic       issue_fp,
  input logic [5:0] sw_flags,
  input logic       sw_es,
  input logic       sw_c1,
  input logic       op_halt,
  input logic       trap_req,
  input logic       issue_go
);
  // R8
  trap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (issue_fp && sw_es));
  // R8
  issue_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fp |-> (trap_req != issue_go));
  // R3
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_flags[3] && !clr_exc) |=> sw_flags[3]);
  // R5
  mem_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dest_mem && op_ovf && !ctl_mask[3] && !sw_flags[5] && !clr_exc)
      |=> (!sw_flags[5] && !sw_c1));
  // R4
  reg_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_inexact && op_unf && !op_dest_mem) |=> (sw_flags[5] && sw_flags[4]));
  // R7
  masked_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (&ctl_mask)) |-> !op_halt);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc && !op_valid) |=> (sw_flags == 6'd0 && !sw_es));
endmodule

bind fpx_flag_unit fpx_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_inexact(op_inexact),
  .op_ovf(op_ovf), .op_unf(op_unf), .op_dest_mem(op_dest_mem),
  .ctl_mask(ctl_mask), .clr_exc(clr_exc), .issue_fp(issue_fp),
  .sw_flags(stat_word[5:0]), .sw_es(stat_word[7]), .sw_c1(stat_word[9]),
  .op_halt(op_halt), .trap_req(trap_req), .issue_go(issue_go)
);

// File: tb/fpx_flag_unit_test.sv
module fpx_flag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_inexact = 0, op_ovf = 0, op_unf = 0, op_roundup = 0, op_dest_mem = 0;
  logic [2:0] op_lo = 0;
  logic [5:0] ctl_mask = 6'h3f;
  logic clr_exc = 0, issue_fp = 0;
  logic [15:0] stat_word;
  logic op_halt, trap_req, issue_go;

  int checks = 0, errors = 0, cyc = 0;
  logic [5:0] m_flg = 0;
  logic m_c1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_flag_unit uut (.*);

  function automatic logic pe_of();
    logic open = (op_ovf & ~ctl_mask[3]) | (op_unf & ~ctl_mask[4]);
    return op_inexact & ~(open & op_dest_mem);
  endfunction

  function automatic logic [5:0] raise_of();
    return op_valid ? {pe_of(), op_unf, op_ovf, op_lo} : 6'd0;
  endfunction

  function automatic logic [15:0] exp_word();
    logic es = |(m_flg & ~ctl_mask);
    return {6'd0, m_c1, 1'b0, es, 1'b0, m_flg};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Check the outputs of the current cycle, then update the model at the edge
  task automatic step();
    logic es;
    #(CLK_PERIOD/4);
    es = |(m_flg & ~ctl_mask);
    chk("R6 status", stat_word, exp_word());
    chk("R7 halt", {15'd0, op_halt}, {15'd0, |(raise_of() & ~ctl_mask)});
    chk("R8 trap", {14'd0, trap_req, issue_go}, {14'd0, issue_fp & es, issue_fp & ~es});
    @(posedge clk);
    m_flg = (clr_exc ? 6'd0 : m_flg) | raise_of();
    if (op_valid) m_c1 = pe_of() & op_roundup;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle();
    op_valid = 0; op_inexact = 0; op_ovf = 0; op_unf = 0; op_lo = 0;
    op_roundup = 0; op_dest_mem = 0; clr_exc = 0; issue_fp = 0;
  endtask

  task automatic op(input logic ix, input logic ov, input logic un, input logic ru, input logic mem);
    idle();
    op_valid = 1; op_inexact = ix; op_ovf = ov; op_unf = un; op_roundup = ru; op_dest_mem = mem;
    step();
    idle();
  endtask

  task automatic clear();
    idle(); clr_exc = 1; step(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 400000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset word", stat_word, 16'h0000);
    chk("R1 reset outs", {14'd0, trap_req, op_halt}, 16'd0);

    // R2 inexact alone, masked, rounded up
    op(1, 0, 0, 1, 0);
    chk("R2 pe+c1", stat_word & 16'h0220, 16'h0220);
    // R10 op without inexact clears C1
    op(0, 0, 0, 0, 0);
    chk("R10 c1 clear", stat_word & 16'h0200, 16'h0000);
    clear();
    chk("R9 clear", stat_word, 16'h0000);

    // R5 unmasked overflow to memory with inexact: no PE, C1 clear, halt
    ctl_mask = 6'h37;
    op(1, 1, 0, 1, 1);
    chk("R5 mem", stat_word & 16'h02a8, 16'h0088);
    // R8 trap on next issue
    idle(); issue_fp = 1; step(); idle();
    clear();

    // R4 unmasked overflow to register with inexact
    op(1, 1, 0, 1, 0);
    chk("R4 reg", stat_word & 16'h02a8, 16'h02a8);
    clear();
    // R4 masked underflow to memory
    ctl_mask = 6'h3f;
    op(1, 0, 1, 0, 1);
    chk("R4 masked", stat_word & 16'h02b0, 16'h0030);
    // R6 unmasking a set flag raises summary, issue traps
    ctl_mask = 6'h1f;
    idle(); issue_fp = 1; step();
    chk("R6 summary", stat_word & 16'h0080, 16'h0080);
    // R9 clear with simultaneous op
    ctl_mask = 6'h3f;
    idle(); clr_exc = 1; op_valid = 1; op_ovf = 1; step(); idle();
    chk("R9 clr+op", stat_word & 16'h003f, 16'h0008);
    clear();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      idle();
      if (r[3:0] == 0) ctl_mask = 6'($urandom);
      op_valid = r[4] | r[5];
      op_inexact = r[6]; op_ovf = r[7] & r[8]; op_unf = r[9] & r[10];
      op_lo = r[13:11] & r[16:14] & r[19:17];
      op_roundup = r[20]; op_dest_mem = r[21];
      clr_exc = (r[26:22] == 0);
      issue_fp = r[27];
      step();
    end
    idle(); step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule